// File: doc/BRIEF.md
# Read-Only Capability Register Window

This block is a small read-only register window for a memory-expansion device. A simple byte-addressed request/response bus reaches it. The window has two regions. The first is a capability directory at offset 0. It opens with a 64-bit header that holds a capability identifier, a version and a capability count. After the header comes one entry that gives the offset and length of the second region. The second region is a device-status area, and every register in it reads as zero.

Each request carries an address, a size code and a read/write flag. The block applies the access rules to every request: the width must be allowed for the register, the address must be naturally aligned, and the bytes must fall inside a single register of a mapped region. A legal read returns its data in little-endian order, right-justified on the data bus. An illegal access returns zero and raises an error flag. Writes are accepted and answered, but they change nothing. The capability contents are built at elaboration from parameters and are stored as 4-byte or 8-byte words. A parameter selects the word width. Narrow reads pick their bytes out of the containing 8-byte group. The decoded window spans the next power of two at or above the end of the status region.

Top module: `cap_window`

## Requirements
- R1: An 8-byte read at offset 0x00 returns the header 0x0000_0001_0001_0000. The capability identifier 0 is in bits [15:0], the version 1 is in bits [23:16] and the capability count 1 is in bits [47:32].
- R2: The capability entry is laid out as follows:
  - Offset 0x10 is a 64-bit register reading 0x0000_0000_0001_0001 (status identifier 1 in bits [15:0], version 1 in bits [23:16]).
  - Offset 0x18 is a 32-bit register holding the status-region offset (default 0x80).
  - Offset 0x1C is a 32-bit register holding the status-region length (default 0x20).
- R3: The size code works as follows:
  - Codes 0, 1, 2 and 3 select 1, 2, 4 and 8 bytes.
  - A legal read returns the register bytes that start at the request address.
  - The byte at the lowest address appears in rsp_rdata[7:0]. Every bit above the access width is zero.
- R4: A legal access anywhere in the status region (default 0x80 to 0x9F) returns zero data with no error.
- R5: An access whose address is not a multiple of its width gets a response with rsp_err set and zero data. It is not split.
- R6: An 8-byte access to the 32-bit registers at 0x18 or 0x1C is flagged with rsp_err and returns zero.
- R7: These addresses are flagged with rsp_err and return zero:
  - the gap between the capability region (default 64 bytes) and the status region;
  - the space after the status region;
  - any address at or above the power-of-two window size (default 0x100).
- R8: A write gets a response with zero data and no stored effect, so later reads are unchanged. It carries rsp_err only when it breaks the width, alignment or range rules.
- R9: rsp_valid is high in exactly the cycle after each cycle with req_valid high, and at no other time. During reset it is low, with rsp_rdata zero.
- R10: Every other byte of the capability region reads as zero. This covers offsets 0x08 to 0x0F and 0x20 up to the end of the region.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W | Byte address in the window |
| req_size | input | 2 | Access size code: 0=1, 1=2, 2=4, 3=8 bytes |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_err | output | 1 | Width, alignment or range violation |
| rsp_rdata | output | 64 | Read data, right-justified little-endian |

## Verification
The response stage holds no state from one request to the next, and the capability words are fixed at elaboration. A wrong value in either of them therefore shows up on rsp_rdata in the cycle after the first read that touches the affected byte. A decode fault is different: it flips rsp_err or leaks data in the response to the first illegal or status-region request it covers. Because every request gets exactly one response one cycle later, a lost or doubled strobe immediately upsets the pairing of requests and responses. A bench scoreboard catches that at once. The bench sweeps every address up to just past the window with every size, so each byte and each decode boundary is reached early.

// File: rtl/cap_win_pkg.sv
package cap_win_pkg;

   typedef enum logic [1:0] {
      ACC_B1 = 2'd0,
      ACC_B2 = 2'd1,
      ACC_B4 = 2'd2,
      ACC_B8 = 2'd3
   } acc_size_e;

   // Fixed layout of the capability directory.
   localparam int unsigned HDR_OFF       = 0;
   localparam int unsigned ENT_OFF       = 16;
   localparam int unsigned ENT_PTR_OFF   = 24;
   localparam int unsigned ENT_LEN_OFF   = 28;
   localparam int unsigned CAP_MIN_BYTES = 32;
   localparam int unsigned STAT_CAP_ID   = 1;
   localparam int unsigned STAT_CAP_VER  = 1;

   function automatic int unsigned ceil_pow2(input int unsigned v);
      int unsigned p;
      p = 1;
      for (int i = 0; i < 32; i++) begin
         if (p < v) p = p << 1;
      end
      return p;
   endfunction

endpackage

// File: rtl/cap_win_decode.sv
module cap_win_decode
   import cap_win_pkg::*;
#(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned CAP_BYTES  = 64,
   parameter int unsigned STAT_OFF   = 128,
   parameter int unsigned STAT_BYTES = 32
) (
   input  logic [ADDR_W-1:0] addr,
   input  acc_size_e         size,
   output logic              hit_cap,
   output logic              legal
);

   localparam int unsigned WIN_BYTES = ceil_pow2(STAT_OFF + STAT_BYTES);
   localparam int unsigned STAT_END  = STAT_OFF + STAT_BYTES;

   logic [ADDR_W-1:0] lo_mask;
   logic              misaligned;
   logic              in_win;
   logic              in_stat;
   logic              narrow_reg;
   logic              too_wide;

   always_comb begin
      lo_mask    = ADDR_W'((32'd1 << size) - 32'd1);
      misaligned = |(addr & lo_mask);
      in_win     = addr < ADDR_W'(WIN_BYTES);
      hit_cap    = in_win && (addr < ADDR_W'(CAP_BYTES));
      in_stat    = in_win && (addr >= ADDR_W'(STAT_OFF)) && (addr < ADDR_W'(STAT_END));
      narrow_reg = hit_cap && (addr >= ADDR_W'(ENT_PTR_OFF))
                           && (addr < ADDR_W'(ENT_LEN_OFF + 4));
      too_wide   = narrow_reg && (size == ACC_B8);
      legal      = (hit_cap || in_stat) && !misaligned && !too_wide;
   end

endmodule

// File: rtl/cap_win_store.sv
module cap_win_store
   import cap_win_pkg::*;
#(
   parameter int unsigned WORD_BYTES  = 8,
   parameter int unsigned CAP_BYTES   = 64,
   parameter int unsigned STAT_OFF    = 128,
   parameter int unsigned STAT_BYTES  = 32,
   parameter int unsigned CAP_VERSION = 1,
   parameter int unsigned CAP_COUNT   = 1,
   localparam int unsigned QIDX_W     = $clog2(CAP_BYTES) - 3
) (
   input  logic [QIDX_W-1:0] quad_idx,
   output logic [63:0]       quad
);

   localparam int unsigned NWORDS = CAP_BYTES / WORD_BYTES;

   function automatic logic [7:0] img_byte(input int unsigned off);
      logic [63:0] hdr;
      logic [63:0] ent;
      logic [31:0] ptr;
      logic [31:0] len;
      hdr         = '0;
      hdr[23:16]  = 8'(CAP_VERSION);
      hdr[47:32]  = 16'(CAP_COUNT);
      ent         = '0;
      ent[15:0]   = 16'(STAT_CAP_ID);
      ent[23:16]  = 8'(STAT_CAP_VER);
      ptr         = 32'(STAT_OFF);
      len         = 32'(STAT_BYTES);
      if (off >= HDR_OFF && off < HDR_OFF + 8)
         return hdr[8*(off-HDR_OFF) +: 8];
      if (off >= ENT_OFF && off < ENT_OFF + 8)
         return ent[8*(off-ENT_OFF) +: 8];
      if (off >= ENT_PTR_OFF && off < ENT_PTR_OFF + 4)
         return ptr[8*(off-ENT_PTR_OFF) +: 8];
      if (off >= ENT_LEN_OFF && off < ENT_LEN_OFF + 4)
         return len[8*(off-ENT_LEN_OFF) +: 8];
      return 8'h00;
   endfunction

   function automatic logic [8*WORD_BYTES-1:0] word_val(input int unsigned w);
      logic [8*WORD_BYTES-1:0] v;
      v = '0;
      for (int unsigned b = 0; b < WORD_BYTES; b++)
         v[8*b +: 8] = img_byte(w*WORD_BYTES + b);
      return v;
   endfunction

   logic [8*WORD_BYTES-1:0] words [NWORDS];

   for (genvar w = 0; w < NWORDS; w++) begin : g_word
      localparam logic [8*WORD_BYTES-1:0] WVAL = word_val(w);
      assign words[w] = WVAL;
   end

   if (WORD_BYTES == 8) begin : g_wide
      assign quad = words[quad_idx];
   end else begin : g_narrow
      logic [QIDX_W:0] lo_i;
      logic [QIDX_W:0] hi_i;
      assign lo_i = {quad_idx, 1'b0};
      assign hi_i = {quad_idx, 1'b1};
      assign quad = {words[hi_i], words[lo_i]};
   end

endmodule

// File: rtl/cap_win_lane.sv
module cap_win_lane
   import cap_win_pkg::*;
(
   input  logic [63:0] quad,
   input  logic [2:0]  byte_off,
   input  acc_size_e   size,
   output logic [63:0] data
);

   logic [63:0] shifted;
   logic [3:0]  nbytes;

   assign shifted = quad >> {byte_off, 3'b000};
   assign nbytes  = 4'd1 << size;

   for (genvar i = 0; i < 8; i++) begin : g_lane
      assign data[8*i +: 8] = (4'(i) < nbytes) ? shifted[8*i +: 8] : 8'h00;
   end

endmodule

// File: rtl/cap_window.sv
module cap_window
   import cap_win_pkg::*;
#(
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned WORD_BYTES  = 8,
   parameter int unsigned CAP_BYTES   = 64,
   parameter int unsigned STAT_OFF    = 128,
   parameter int unsigned STAT_BYTES  = 32,
   parameter int unsigned CAP_VERSION = 1,
   parameter int unsigned CAP_COUNT   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_size,
   output logic              rsp_valid,
   output logic              rsp_err,
   output logic [63:0]       rsp_rdata
);

   localparam int unsigned WIN_BYTES = ceil_pow2(STAT_OFF + STAT_BYTES);
   localparam int unsigned CAP_LG    = $clog2(CAP_BYTES);
   localparam int unsigned QIDX_W    = CAP_LG - 3;

   // Elaboration-time parameter checks.
   if (WORD_BYTES != 4 && WORD_BYTES != 8) begin : g_bad_word
      $error("WORD_BYTES must be 4 or 8");
   end
   if (CAP_BYTES < CAP_MIN_BYTES || (1 << CAP_LG) != CAP_BYTES) begin : g_bad_cap
      $error("CAP_BYTES must be a power of two of at least 32");
   end
   if (STAT_OFF < CAP_BYTES || (STAT_OFF % 8) != 0) begin : g_bad_soff
      $error("STAT_OFF must be 8-aligned and past the capability region");
   end
   if (STAT_BYTES == 0 || (STAT_BYTES % 8) != 0) begin : g_bad_slen
      $error("STAT_BYTES must be a non-zero multiple of 8");
   end
   if ($clog2(WIN_BYTES) >= ADDR_W) begin : g_bad_aw
      $error("ADDR_W too narrow for the window");
   end

   acc_size_e          size_e;
   logic               dec_cap;
   logic               dec_legal;
   logic [QIDX_W-1:0]  quad_idx;
   logic [63:0]        quad;
   logic [63:0]        lane_data;

   assign size_e   = acc_size_e'(req_size);
   assign quad_idx = req_addr[CAP_LG-1:3];

   cap_win_decode #(
      .ADDR_W    (ADDR_W),
      .CAP_BYTES (CAP_BYTES),
      .STAT_OFF  (STAT_OFF),
      .STAT_BYTES(STAT_BYTES)
   ) u_decode (
      .addr   (req_addr),
      .size   (size_e),
      .hit_cap(dec_cap),
      .legal  (dec_legal)
   );

   cap_win_store #(
      .WORD_BYTES (WORD_BYTES),
      .CAP_BYTES  (CAP_BYTES),
      .STAT_OFF   (STAT_OFF),
      .STAT_BYTES (STAT_BYTES),
      .CAP_VERSION(CAP_VERSION),
      .CAP_COUNT  (CAP_COUNT)
   ) u_store (
      .quad_idx(quad_idx),
      .quad    (quad)
   );

   cap_win_lane u_lane (
      .quad    (quad),
      .byte_off(req_addr[2:0]),
      .size    (size_e),
      .data    (lane_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_err   <= req_valid && !dec_legal;
         rsp_rdata <= (req_valid && !req_write && dec_legal && dec_cap) ? lane_data : '0;
      end
   end

endmodule

// File: rtl/cap_window_chk.sv
module cap_window_chk
   import cap_win_pkg::*;
#(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned STAT_OFF   = 128,
   parameter int unsigned STAT_BYTES = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic [ADDR_W-1:0] req_addr,
   input logic [1:0]        req_size,
   input logic              rsp_valid,
   input logic              rsp_err,
   input logic [63:0]       rsp_rdata
);

   localparam int unsigned WIN_BYTES = ceil_pow2(STAT_OFF + STAT_BYTES);

   logic [ADDR_W-1:0] amask;
   logic              stat_hit;
   assign amask    = ADDR_W'((32'd1 << req_size) - 32'd1);
   assign stat_hit = (req_addr >= ADDR_W'(STAT_OFF)) &&
                     (req_addr < ADDR_W'(STAT_OFF + STAT_BYTES));

   assert_rsp_follows_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   assert_no_spurious_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   assert_err_data_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (rsp_rdata == '0));

   assert_misalign_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (|(req_addr & amask))) |=> rsp_err);

   assert_wide_on_narrow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_size == 2'd3 &&
       (req_addr == ADDR_W'(ENT_PTR_OFF) || req_addr == ADDR_W'(ENT_LEN_OFF))) |=> rsp_err);

   assert_outside_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_addr >= ADDR_W'(WIN_BYTES)) |=> rsp_err);

   assert_write_no_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write) |=> (rsp_rdata == '0));

   assert_byte_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_size == 2'd0) |=> (rsp_rdata[63:8] == '0));

   assert_status_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && stat_hit) |=> (rsp_rdata == '0));

endmodule

bind cap_window cap_window_chk #(
   .ADDR_W    (ADDR_W),
   .STAT_OFF  (STAT_OFF),
   .STAT_BYTES(STAT_BYTES)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_valid(req_valid),
   .req_write(req_write),
   .req_addr (req_addr),
   .req_size (req_size),
   .rsp_valid(rsp_valid),
   .rsp_err  (rsp_err),
   .rsp_rdata(rsp_rdata)
);

// File: tb/cap_window_test.sv
`timescale 1ns/1ps
module cap_window_test;

   localparam int AW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [1:0]    req_size = '0;
   logic          rsp_valid;
   logic          rsp_err;
   logic [63:0]   rsp_rdata;

   always #4 clk = ~clk;

   cap_window uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_valid(req_valid),
      .req_write(req_write),
      .req_addr (req_addr),
      .req_size (req_size),
      .rsp_valid(rsp_valid),
      .rsp_err  (rsp_err),
      .rsp_rdata(rsp_rdata)
   );

   typedef struct {
      logic [63:0] data;
      logic        err;
      string       tag;
   } exp_t;

   exp_t sbq[$];
   int   checks = 0;
   int   fails  = 0;
   int   issued = 0;
   int   seen   = 0;
   bit   done   = 0;

   task automatic check(input bit ok, input string tag,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   // Reference image of the capability region, taken from R1, R2 and R10.
   function automatic logic [7:0] img(input int a);
      case (a)
         2, 4, 16, 18: return 8'h01;
         24:           return 8'h80;
         28:           return 8'h20;
         default:      return 8'h00;
      endcase
   endfunction

   function automatic bit legal(input int a, input int sz);
      int n;
      n = 1 << sz;
      if ((a % n) != 0) return 0;
      if (a < 64) return !(sz == 3 && a >= 24 && a < 32);
      return (a >= 128 && a < 160);
   endfunction

   function automatic logic [63:0] model(input int a, input int sz, input bit wr);
      logic [63:0] v;
      v = '0;
      if (!legal(a, sz) || wr || a >= 64) return v;
      for (int i = 0; i < (1 << sz); i++) v[8*i +: 8] = img(a + i);
      return v;
   endfunction

   task automatic send(input int a, input int sz, input bit wr,
                       input logic [63:0] exp_d, input bit exp_e, input string tag);
      exp_t e;
      @(negedge clk);
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = AW'(a);
      req_size  = 2'(sz);
      e.data = exp_d;
      e.err  = exp_e;
      e.tag  = tag;
      sbq.push_back(e);
      issued++;
   endtask

   task automatic idle();
      @(negedge clk);
      req_valid = 1'b0;
      req_write = 1'b0;
   endtask

   // Monitor: pairs each response with the oldest outstanding expectation.
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         seen++;
         if (sbq.size() == 0) begin
            check(0, "R9 response without request", 64'(rsp_valid), 64'd0);
         end else begin
            exp_t e;
            e = sbq.pop_front();
            check(rsp_err == e.err, {e.tag, " err"}, 64'(rsp_err), 64'(e.err));
            check(rsp_rdata == e.data, {e.tag, " data"}, rsp_rdata, e.data);
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      check(0, "R9 watchdog expired", 64'(issued), 64'(seen));
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check(rsp_valid == 1'b0, "R9 reset valid", 64'(rsp_valid), 64'd0);
      check(rsp_rdata == '0, "R9 reset data", rsp_rdata, 64'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(rsp_valid == 1'b0, "R9 idle after reset", 64'(rsp_valid), 64'd0);

      send(0, 3, 0, 64'h0000_0001_0001_0000, 0, "R1 header");
      send(16, 3, 0, 64'h0000_0000_0001_0001, 0, "R2 entry id");
      send(24, 2, 0, 64'h80, 0, "R2 entry offset");
      send(28, 2, 0, 64'h20, 0, "R2 entry length");
      send(2, 0, 0, 64'h01, 0, "R3 byte read");
      send(0, 2, 0, 64'h0001_0000, 0, "R3 low dword");
      send(4, 1, 0, 64'h0001, 0, "R3 half read");
      send(24, 0, 0, 64'h80, 0, "R3 byte of 32-bit reg");
      send(26, 1, 0, 64'h0, 0, "R3 upper half of 32-bit reg");
      send(8, 3, 0, 64'h0, 0, "R10 reserved 0x08");
      send(32, 3, 0, 64'h0, 0, "R10 reserved 0x20");
      send(56, 2, 0, 64'h0, 0, "R10 reserved 0x38");
      send(128, 3, 0, 64'h0, 0, "R4 status qword");
      send(152, 0, 0, 64'h0, 0, "R4 status byte");
      send(1, 1, 0, 64'h0, 1, "R5 misaligned half");
      send(4, 3, 0, 64'h0, 1, "R5 misaligned qword");
      send(18, 2, 0, 64'h0, 1, "R5 misaligned dword");
      send(24, 3, 0, 64'h0, 1, "R6 qword at 0x18");
      send(28, 3, 0, 64'h0, 1, "R6 qword at 0x1C");
      send(64, 3, 0, 64'h0, 1, "R7 gap start");
      send(120, 2, 0, 64'h0, 1, "R7 gap end");
      send(160, 3, 0, 64'h0, 1, "R7 past status");
      send(256, 0, 0, 64'h0, 1, "R7 window edge");
      send(16'hFFF8, 3, 0, 64'h0, 1, "R7 top of address space");
      send(0, 3, 1, 64'h0, 0, "R8 legal write");
      send(1, 1, 1, 64'h0, 1, "R8 misaligned write");
      send(128, 3, 1, 64'h0, 0, "R8 status write");
      send(0, 3, 0, 64'h0000_0001_0001_0000, 0, "R8 header unchanged");
      idle();
      idle();
      check(rsp_valid == 1'b0, "R9 no response when idle", 64'(rsp_valid), 64'd0);

      for (int a = 0; a < 272; a++) begin
         for (int sz = 0; sz < 4; sz++) begin
            send(a, sz, 0, model(a, sz, 0), !legal(a, sz),
                 $sformatf("R3/R5/R6/R7 sweep a=%0h s=%0d", a, sz));
         end
      end
      idle();
      idle();
      check(sbq.size() == 0, "R9 all responses returned", 64'(sbq.size()), 64'd0);
      check(issued == seen, "R9 response count", 64'(seen), 64'(issued));
      finish_run();
   end

endmodule